// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital control half of a dual-slope integrating converter. A master clock is divided by four into a count clock. On that count clock a three-state machine steps through auto-zero (`AZ`), signal integrate (`INT`) and reference de-integrate (`DEINT`), and drives one phase strobe per state to the analog switch drivers. While in `DEINT`, a four-decade BCD counter accumulates counts. When the synchronized comparator leaves the level it had at the start of `DEINT`, the count is captured into a display latch. The latch feeds seven-segment decoders.

The measure cycle always lasts 4000 counts. `INT` is fixed at 1000 counts and `DEINT` may run for up to 2000. `AZ` takes whatever remains, so it lasts between 1000 and 3000 counts. The state transitions are:
- `AZ`→`INT` when the shared cycle counter reaches its last value.
- `INT`→`DEINT` after 1000 counts.
- `DEINT`→`AZ` on a comparator trip or at the 2000-count limit.
- Any state→`AZ` on reset.

If `DEINT` hits its limit without a trip, an overrange flag is raised and a dash pattern is latched in place of a count. A test input lights every segment without touching the sequence.

Top module: `adc_dual_slope_seq`

## Requirements
- R1: One count is four master clocks; the `INT` strobe stays high for exactly 1000 counts (4000 clocks) per conversion.
- R2: The comparator passes through two flops. `DEINT` ends at the first count tick where the synchronized level differs from its level on entry to `DEINT`. The latch then takes the number of counts that completed before that tick, from 0 to 1999, in BCD with the ones digit at bits [3:0], tens at [7:4], hundreds at [11:8] and thousands at [15:12].
- R3: If no trip occurs within 2000 `DEINT` counts, `DEINT` ends, `over_range` goes to 1 and every latched digit becomes 4'hF.
- R4: `AZ` lasts 3000 − k counts, where k is the number of `DEINT` counts, so every conversion is 4000 counts (16000 clocks).
- R5: A synchronous reset puts the block in `AZ` with the latch and counters at zero and `over_range` low. The first `AZ` after reset lasts 1000 counts.
- R6: Exactly one of `ph_az`, `ph_int`, `ph_deint` is high in every cycle.
- R7: The latched digits change only when leaving `DEINT`. Comparator changes during `AZ` or `INT` have no effect on the latch or the phase timing.
- R8: The segment outputs are active high, with bit 0 = a through bit 6 = g and digit n at bits [7n+6:7n]. Digits 0 to 9 use the standard patterns: 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F, 9=7'h6F. Any value above 9 shows only segment g (7'h40).
- R9: While `test_all_on` is 1, every segment output is 1, and the phases and latch continue undisturbed.
- R10: An in-range result clears `over_range` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Comparator output bit |
| test_all_on | input | 1 | Force all segments on |
| ph_az | output | 1 | Auto-zero phase strobe |
| ph_int | output | 1 | Signal integrate phase strobe |
| ph_deint | output | 1 | Reference de-integrate phase strobe |
| bcd_out | output | 4*DIGITS | Latched BCD digits |
| seg_out | output | 7*DIGITS | Seven-segment patterns, all digits |
| over_range | output | 1 | Last conversion exceeded the de-integrate window |

## Verification
Conversions are run with trip points of 1, 2, 124, 1000 and 2000 counts and with no trip at all. These cases separate an off-by-one in the trip-to-latch latency, decade carries at single, double and triple rollovers, the last in-range slot against the overrange path, and the `AZ` stretch that each `DEINT` length must produce. Alternating the comparator's starting level between conversions shows that the trip follows a change of level rather than a fixed polarity. Comparator toggles during `AZ` and a test-mode pulse must leave the latch and the phase lengths intact. A reset applied during `DEINT` must return the block to its initial state.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2
    } phase_e;

    function automatic logic [6:0] seg7_of(input logic [3:0] v);
        logic [6:0] s;
        case (v)
            4'd0: s = 7'h3F;
            4'd1: s = 7'h06;
            4'd2: s = 7'h5B;
            4'd3: s = 7'h4F;
            4'd4: s = 7'h66;
            4'd5: s = 7'h6D;
            4'd6: s = 7'h7D;
            4'd7: s = 7'h07;
            4'd8: s = 7'h7F;
            4'd9: s = 7'h6F;
            default: s = 7'h40;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/adc_cnt_tick.sv
module adc_cnt_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + DW'(1);
    end
endmodule

// File: rtl/adc_bcd_chain.sv
module adc_bcd_chain #(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  en,
    output logic [4*DIGITS-1:0]   value
);
    logic [DIGITS:0] carry;

    assign carry[0] = en;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dec
        logic [3:0] d;
        assign carry[g+1] = carry[g] && (d == 4'd9);
        assign value[4*g +: 4] = d;
        always_ff @(posedge clk) begin
            if (clr)           d <= 4'd0;
            else if (carry[g]) d <= (d == 4'd9) ? 4'd0 : d + 4'd1;
        end
    end
endmodule

// File: rtl/adc_seg7_bank.sv
module adc_seg7_bank
    import adc_seq_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] bcd,
    input  logic                force_on,
    output logic [7*DIGITS-1:0] seg
);
    for (genvar g = 0; g < DIGITS; g++) begin : g_seg
        assign seg[7*g +: 7] = force_on ? 7'h7F : seg7_of(bcd[4*g +: 4]);
    end
endmodule

// File: rtl/adc_dual_slope_seq.sv
module adc_dual_slope_seq
    import adc_seq_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int INT_COUNTS = 1000,
    parameter int DEINT_MAX  = 2000,
    parameter int AZ_MIN     = 1000,
    parameter int DIGITS     = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmp_in,
    input  logic                test_all_on,
    output logic                ph_az,
    output logic                ph_int,
    output logic                ph_deint,
    output logic [4*DIGITS-1:0] bcd_out,
    output logic [7*DIGITS-1:0] seg_out,
    output logic                over_range
);
    localparam int CYCLE_COUNTS = INT_COUNTS + DEINT_MAX + AZ_MIN;
    localparam int CW           = $clog2(CYCLE_COUNTS);
    localparam logic [CW-1:0] INT_LAST   = CW'(INT_COUNTS - 1);
    localparam logic [CW-1:0] DEINT_LAST = CW'(INT_COUNTS + DEINT_MAX - 1);
    localparam logic [CW-1:0] CYC_LAST   = CW'(CYCLE_COUNTS - 1);
    localparam logic [CW-1:0] AZ_START   = CW'(INT_COUNTS + DEINT_MAX);

    phase_e        state, state_nx;
    logic [CW-1:0] cyc, cyc_nx;
    logic          tick;
    logic          cmp_meta, cmp_s, ref_lvl;
    logic          trip, limit, start_deint;
    logic [4*DIGITS-1:0] count;

    adc_cnt_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_meta <= 1'b0;
            cmp_s    <= 1'b0;
        end else begin
            cmp_meta <= cmp_in;
            cmp_s    <= cmp_meta;
        end
    end

    assign trip        = tick && (state == PH_DEINT) && (cmp_s != ref_lvl);
    assign limit       = tick && (state == PH_DEINT) && !trip && (cyc == DEINT_LAST);
    assign start_deint = tick && (state == PH_INT) && (cyc == INT_LAST);

    // next-state and cycle position
    always_comb begin
        state_nx = state;
        cyc_nx   = cyc;
        if (tick) begin
            unique case (state)
                PH_AZ: begin
                    if (cyc == CYC_LAST) begin
                        cyc_nx   = '0;
                        state_nx = PH_INT;
                    end else begin
                        cyc_nx = cyc + CW'(1);
                    end
                end
                PH_INT: begin
                    cyc_nx = cyc + CW'(1);
                    if (cyc == INT_LAST) state_nx = PH_DEINT;
                end
                PH_DEINT: begin
                    cyc_nx = cyc + CW'(1);
                    if (trip || limit) state_nx = PH_AZ;
                end
                default: state_nx = PH_AZ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PH_AZ;
            cyc     <= AZ_START;
            ref_lvl <= 1'b0;
        end else begin
            state <= state_nx;
            cyc   <= cyc_nx;
            if (start_deint) ref_lvl <= cmp_s;
        end
    end

    // output decode
    always_comb begin
        ph_az    = 1'b0;
        ph_int   = 1'b0;
        ph_deint = 1'b0;
        unique case (state)
            PH_AZ:    ph_az    = 1'b1;
            PH_INT:   ph_int   = 1'b1;
            PH_DEINT: ph_deint = 1'b1;
            default:  ph_az    = 1'b1;
        endcase
    end

    adc_bcd_chain #(.DIGITS(DIGITS)) u_count (
        .clk   (clk),
        .clr   (rst || start_deint),
        .en    (tick && (state == PH_DEINT) && !trip),
        .value (count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bcd_out    <= '0;
            over_range <= 1'b0;
        end else if (trip) begin
            bcd_out    <= count;
            over_range <= 1'b0;
        end else if (limit) begin
            bcd_out    <= '1;
            over_range <= 1'b1;
        end
    end

    adc_seg7_bank #(.DIGITS(DIGITS)) u_seg (
        .bcd      (bcd_out),
        .force_on (test_all_on),
        .seg      (seg_out)
    );
endmodule

// File: rtl/adc_dual_slope_seq_chk.sv
module adc_dual_slope_seq_chk #(
    parameter int CLK_DIV    = 4,
    parameter int INT_COUNTS = 1000,
    parameter int DIGITS     = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                test_all_on,
    input logic                ph_az,
    input logic                ph_int,
    input logic                ph_deint,
    input logic [4*DIGITS-1:0] bcd_out,
    input logic [7*DIGITS-1:0] seg_out,
    input logic                over_range
);
    logic [31:0] int_len;

    always_ff @(posedge clk) begin
        if (rst)         int_len <= '0;
        else if (ph_int) int_len <= int_len + 32'd1;
        else             int_len <= '0;
    end

    a_r6_one_phase: assert property (@(posedge clk) disable iff (rst)
        $countones({ph_az, ph_int, ph_deint}) == 1);

    a_r5_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ph_az && (bcd_out == '0) && !over_range));

    a_r7_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !ph_deint |=> $stable(bcd_out));

    a_r3_over_code: assert property (@(posedge clk) disable iff (rst)
        $rose(over_range) |-> ((&bcd_out) && ph_az && $past(ph_deint)));

    a_r9_force_on: assert property (@(posedge clk) disable iff (rst)
        test_all_on |-> (&seg_out));

    a_r1_int_len: assert property (@(posedge clk) disable iff (rst)
        $fell(ph_int) |-> (int_len == 32'(INT_COUNTS * CLK_DIV)));
endmodule

bind adc_dual_slope_seq adc_dual_slope_seq_chk #(
    .CLK_DIV    (CLK_DIV),
    .INT_COUNTS (INT_COUNTS),
    .DIGITS     (DIGITS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .test_all_on (test_all_on),
    .ph_az       (ph_az),
    .ph_int      (ph_int),
    .ph_deint    (ph_deint),
    .bcd_out     (bcd_out),
    .seg_out     (seg_out),
    .over_range  (over_range)
);

// File: tb/tb_adc_dual_slope_seq.sv
module tb_adc_dual_slope_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam int NV         = 7;
    // de-integrate trip count (0 = never trips), starting level, expected latch
    localparam int          VN [NV] = '{1, 2, 124, 1000, 2000, 0, 57};
    localparam bit          VL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [15:0] VE [NV] = '{16'h0000, 16'h0001, 16'h0123, 16'h0999,
                                        16'h1999, 16'hFFFF, 16'h0056};

    logic clk = 1'b0;
    logic rst, cmp_in, test_all_on;
    logic ph_az, ph_int, ph_deint, over_range;
    logic [15:0] bcd_out;
    logic [27:0] seg_out;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_dual_slope_seq dut (
        .clk(clk), .rst(rst), .cmp_in(cmp_in), .test_all_on(test_all_on),
        .ph_az(ph_az), .ph_int(ph_int), .ph_deint(ph_deint),
        .bcd_out(bcd_out), .seg_out(seg_out), .over_range(over_range)
    );

    function automatic logic [6:0] ref_seg(input logic [3:0] v);
        logic [6:0] s;
        case (v)
            4'd0: s = 7'h3F; 4'd1: s = 7'h06; 4'd2: s = 7'h5B; 4'd3: s = 7'h4F;
            4'd4: s = 7'h66; 4'd5: s = 7'h6D; 4'd6: s = 7'h7D; 4'd7: s = 7'h07;
            4'd8: s = 7'h7F; 4'd9: s = 7'h6F; default: s = 7'h40;
        endcase
        return s;
    endfunction

    function automatic logic [27:0] ref_segs(input logic [15:0] b);
        return {ref_seg(b[15:12]), ref_seg(b[11:8]), ref_seg(b[7:4]), ref_seg(b[3:0])};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        logic [15:0] prev;
        rst = 1'b1; cmp_in = VL[0]; test_all_on = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R5: reset state
        chk(ph_az && !ph_int && !ph_deint, "R5 phase", {ph_az, ph_int, ph_deint}, 3'b100);
        chk(bcd_out == 16'h0 && !over_range, "R5 latch", {bcd_out, over_range}, 0);
        chk(seg_out == ref_segs(16'h0), "R8 zero segs", seg_out, ref_segs(16'h0));
        cnt = 0;
        while (!ph_int) begin cnt++; @(negedge clk); end
        chk(cnt == 4000, "R5 first az length", cnt, 4000);
        prev = 16'h0;

        for (int i = 0; i < NV; i++) begin
            int k;
            k = (VN[i] == 0) ? 2000 : VN[i];
            cnt = 0;
            while (ph_int) begin cnt++; @(negedge clk); end
            chk(cnt == 4000, "R1 int length", cnt, 4000);
            chk(bcd_out == prev, "R7 hold into deint", bcd_out, prev);
            if (VN[i] > 0) begin
                repeat (4 * VN[i] - 3) @(negedge clk);
                cmp_in = ~VL[i];
            end
            while (ph_deint) @(negedge clk);
            // R2 / R3 / R10 result
            chk(bcd_out == VE[i], "R2 R3 latched value", bcd_out, VE[i]);
            chk(over_range == (VE[i] == 16'hFFFF), "R3 R10 overrange flag",
                over_range, (VE[i] == 16'hFFFF));
            chk(seg_out == ref_segs(VE[i]), "R8 segments", seg_out, ref_segs(VE[i]));
            cnt = 0;
            while (!ph_int) begin
                cnt++;
                if (cnt == 100) cmp_in = (i + 1 < NV) ? VL[i+1] : ~cmp_in;
                if (i == 3 && cnt == 200) test_all_on = 1'b1;
                if (i == 3 && cnt == 204)
                    chk(seg_out == '1, "R9 all segments on", seg_out, 28'hFFFFFFF);
                if (i == 3 && cnt == 208) test_all_on = 1'b0;
                if (i == 3 && cnt == 212)
                    chk(seg_out == ref_segs(VE[i]), "R9 segments restored",
                        seg_out, ref_segs(VE[i]));
                @(negedge clk);
            end
            chk(cnt == 4 * (3000 - k), "R4 az length", cnt, 4 * (3000 - k));
            chk(bcd_out == VE[i], "R7 hold through az", bcd_out, VE[i]);
            prev = VE[i];
        end

        // R5: reset during de-integrate
        while (!ph_deint) @(negedge clk);
        repeat (37) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(ph_az && !ph_deint, "R5 reset mid deint", {ph_az, ph_int, ph_deint}, 3'b100);
        chk(bcd_out == 16'h0 && !over_range, "R5 reset clears latch", bcd_out, 0);
        cnt = 0;
        while (!ph_int) begin cnt++; @(negedge clk); end
        chk(cnt == 4000, "R5 az after reset", cnt, 4000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule